// File: doc/BRIEF.md
# Dual-CPU Mailbox Control and Interrupt Logic

This block is the control word and interrupt source of a byte-wide mailbox that links a host processor to a second, parasite processor. The host changes the control word with mask writes to offset 0. Bit 7 of the written byte chooses the action. When bit 7 is one, each of bits 5:0 that is one sets the matching control bit. When bit 7 is zero, each of those bits that is one clears the matching control bit. Control bits that the mask does not select keep their value.

The control bits enable four interrupt paths and select the two-byte mode of channel 3. They also hold the parasite processor in reset. A set write that carries bit 6 sends a one-cycle clear strobe to the channel logic, and that strobe does not change the control word. A clear write that removes the reset bit sends a one-cycle reset pulse to the parasite processor. The channel data paths are not part of this block. They supply only their data-available and space-available flags. From those flags the block drives a host IRQ, a parasite IRQ and a parasite NMI. Each of these is a registered, level-sensitive output.

Top module: `mbx_ctrl_top`

## Requirements
- R1: After reset, every output is 0 and a read of offset 0 returns 0 in bits 5:0.
- R2: A host write to offset 0 with bit 7 = 1 ORs data bits 5:0 into the control bits. The new value can be read back one clock later.
- R3: A host write to offset 0 with bit 7 = 0 clears each control bit whose data bit (5:0) is 1. All other control bits stay as they were.
- R4: A host read returns a value that depends on the offset. At offset 0 it returns {channel-1 host data-available, channel-1 host space-available, control bits 5:0}. At any other offset it returns 0.
- R5: A set write (bit 7 = 1) with bit 6 = 1 raises the clear strobe for exactly the one clock that follows the write. Bit 6 is never stored, so it reads back as part of the status flags and never as a control bit.
- R6: A clear write (bit 7 = 0) with bit 5 = 1 while control bit 5 is 1 raises the parasite reset pulse for exactly the one clock that follows. When control bit 5 is already 0, such a write gives no pulse.
- R7: The parasite hold output equals control bit 5 (1 = parasite held).
- R8: Host IRQ is 1 when control bit 0 is 1 and the channel-4 host-side data-available flag is 1.
- R9: Parasite IRQ is 1 when control bit 1 is 1 and the channel-1 parasite data flag is 1, or when control bit 2 is 1 and the channel-4 parasite data flag is 1.
- R10: Parasite NMI is 1 when control bit 3 is 1 and the channel-3 parasite data flag is 1.
- R11: Each interrupt output is registered. It follows a change of a flag one clock later, and it follows a change of the control bits two clocks after the write.
- R12: Control bit 4 (two-byte mode of channel 3) is driven out on a port of its own and has no effect on any interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low synchronous full reset |
| hostWr | input | 1 | Host write strobe |
| hostAddr | input | 3 | Host register offset |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data (combinational) |
| ch1HostFlags | input | 2 | Channel-1 host status: bit 1 = data available, bit 0 = space available |
| ch4HostData | input | 1 | Channel-4 host-side data available |
| ch1ParData | input | 1 | Channel-1 parasite-side data available |
| ch3ParData | input | 1 | Channel-3 parasite-side data available |
| ch4ParData | input | 1 | Channel-4 parasite-side data available |
| hostIrq | output | 1 | Host interrupt request |
| parIrq | output | 1 | Parasite interrupt request |
| parNmi | output | 1 | Parasite non-maskable interrupt |
| parResetPulse | output | 1 | One-cycle parasite reset pulse |
| parHold | output | 1 | Parasite held in reset |
| chanClear | output | 1 | One-cycle clear strobe to all channels |
| twoByteMode | output | 1 | Channel-3 two-byte mode select |

## Verification
The random writes mix set and clear operations under random masks, so the read-back compares set semantics against clear semantics, and it also shows whether unselected bits are kept. The flags change at random against random enables. This separates each interrupt's own enable and channel from the neighbouring ones, and it shows whether the two parasite IRQ sources are combined with OR. Directed sequences cover three cases: a clear write of bit 5 both with and without bit 5 stored, repeated clear strobes with bit 6, and a flag change sampled before and after the clock edge, which exposes the one-cycle register stage on the interrupts.

// File: rtl/mbx_ctrl_pkg.sv
package mbx_ctrl_pkg;
  localparam int CTRL_W  = 6;
  localparam int DATA_W  = 8;
  localparam int B_HIRQ4 = 0;
  localparam int B_PIRQ1 = 1;
  localparam int B_PIRQ4 = 2;
  localparam int B_PNMI3 = 3;
  localparam int B_TWOB  = 4;
  localparam int B_PRST  = 5;
  localparam int B_CLR   = 6;
  localparam int B_SET   = 7;

  typedef struct packed {
    logic              setEn;
    logic              clrEn;
    logic [CTRL_W-1:0] mask;
    logic              clearReq;
    logic              resetReq;
  } ctrl_cmd_t;
endpackage

// File: rtl/mbx_ctrl_decode.sv
module mbx_ctrl_decode
  import mbx_ctrl_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [CTRL_W-1:0] ctrlBits,
  output ctrl_cmd_t         cmd
);
  logic selCtrl;
  logic isSet;

  always_comb begin
    selCtrl      = hostWr && (hostAddr == '0);
    isSet        = hostWrData[B_SET];
    cmd.setEn    = selCtrl && isSet;
    cmd.clrEn    = selCtrl && !isSet;
    cmd.mask     = hostWrData[CTRL_W-1:0];
    cmd.clearReq = selCtrl && isSet && hostWrData[B_CLR];
    cmd.resetReq = selCtrl && !isSet && hostWrData[B_PRST] && ctrlBits[B_PRST];
  end
endmodule

// File: rtl/mbx_ctrl_datapath.sv
module mbx_ctrl_datapath
  import mbx_ctrl_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_cmd_t         cmd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        ch1HostFlags,
  input  logic              ch4HostData,
  input  logic              ch1ParData,
  input  logic              ch3ParData,
  input  logic              ch4ParData,
  output logic [CTRL_W-1:0] ctrlBits,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostIrq,
  output logic              parIrq,
  output logic              parNmi,
  output logic              parResetPulse,
  output logic              chanClear
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [CTRL_W-1:0] ctrlNext;

  always_comb begin
    ctrlNext = ctrlQ;
    if (cmd.setEn) ctrlNext = ctrlQ | cmd.mask;
    else if (cmd.clrEn) ctrlNext = ctrlQ & ~cmd.mask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ         <= '0;
      chanClear     <= 1'b0;
      parResetPulse <= 1'b0;
      hostIrq       <= 1'b0;
      parIrq        <= 1'b0;
      parNmi        <= 1'b0;
    end else begin
      ctrlQ         <= ctrlNext;
      chanClear     <= cmd.clearReq;
      parResetPulse <= cmd.resetReq;
      hostIrq       <= ctrlQ[B_HIRQ4] && ch4HostData;
      parIrq        <= (ctrlQ[B_PIRQ1] && ch1ParData) || (ctrlQ[B_PIRQ4] && ch4ParData);
      parNmi        <= ctrlQ[B_PNMI3] && ch3ParData;
    end
  end

  assign ctrlBits   = ctrlQ;
  assign hostRdData = (hostAddr == '0) ? {ch1HostFlags, ctrlQ} : '0;
endmodule

// File: rtl/mbx_ctrl_top.sv
module mbx_ctrl_top
  import mbx_ctrl_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  input  logic [1:0]        ch1HostFlags,
  input  logic              ch4HostData,
  input  logic              ch1ParData,
  input  logic              ch3ParData,
  input  logic              ch4ParData,
  output logic              hostIrq,
  output logic              parIrq,
  output logic              parNmi,
  output logic              parResetPulse,
  output logic              parHold,
  output logic              chanClear,
  output logic              twoByteMode
);
  ctrl_cmd_t         cmd;
  logic [CTRL_W-1:0] ctrlBits;

  mbx_ctrl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .hostWr(hostWr), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .ctrlBits(ctrlBits), .cmd(cmd)
  );

  mbx_ctrl_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hostAddr(hostAddr),
    .ch1HostFlags(ch1HostFlags), .ch4HostData(ch4HostData),
    .ch1ParData(ch1ParData), .ch3ParData(ch3ParData), .ch4ParData(ch4ParData),
    .ctrlBits(ctrlBits), .hostRdData(hostRdData),
    .hostIrq(hostIrq), .parIrq(parIrq), .parNmi(parNmi),
    .parResetPulse(parResetPulse), .chanClear(chanClear)
  );

  assign parHold     = ctrlBits[B_PRST];
  assign twoByteMode = ctrlBits[B_TWOB];
endmodule

// File: rtl/mbx_ctrl_checker.sv
module mbx_ctrl_checker #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWr,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [7:0]        hostWrData,
  input logic              ch4HostData,
  input logic              ch3ParData,
  input logic              ch1ParData,
  input logic              ch4ParData,
  input logic              hostIrq,
  input logic              parIrq,
  input logic              parNmi,
  input logic              parResetPulse,
  input logic              parHold,
  input logic              chanClear
);
  logic ctrlSel;
  assign ctrlSel = hostWr && (hostAddr == '0);

  p_set_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlSel && hostWrData[7] && hostWrData[5]) |=> parHold);

  p_clr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlSel && !hostWrData[7] && hostWrData[5]) |=> !parHold);

  p_clear_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    chanClear |-> $past(ctrlSel && hostWrData[7] && hostWrData[6]));

  p_clear_issue_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlSel && hostWrData[7] && hostWrData[6]) |=> chanClear);

  p_rst_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    parResetPulse |-> ($past(parHold) && !parHold));

  p_hirq_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> $past(ch4HostData));

  p_pirq_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    parIrq |-> $past(ch1ParData || ch4ParData));

  p_pnmi_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    parNmi |-> $past(ch3ParData));
endmodule

bind mbx_ctrl_top mbx_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
  .hostWrData(hostWrData), .ch4HostData(ch4HostData), .ch3ParData(ch3ParData),
  .ch1ParData(ch1ParData), .ch4ParData(ch4ParData), .hostIrq(hostIrq),
  .parIrq(parIrq), .parNmi(parNmi), .parResetPulse(parResetPulse),
  .parHold(parHold), .chanClear(chanClear)
);

// File: tb/mbx_ctrl_top_tb_top.sv
module mbx_ctrl_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic [1:0] ch1HostFlags = '0;
  logic       ch4HostData = 1'b0, ch1ParData = 1'b0, ch3ParData = 1'b0, ch4ParData = 1'b0;
  logic       hostIrq, parIrq, parNmi, parResetPulse, parHold, chanClear, twoByteMode;

  int checks = 0;
  int fails = 0;
  logic [5:0] model = '0;
  bit done = 0;

  always #5 clk = ~clk;

  mbx_ctrl_top dut_i (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .ch1HostFlags(ch1HostFlags),
    .ch4HostData(ch4HostData), .ch1ParData(ch1ParData), .ch3ParData(ch3ParData),
    .ch4ParData(ch4ParData), .hostIrq(hostIrq), .parIrq(parIrq), .parNmi(parNmi),
    .parResetPulse(parResetPulse), .parHold(parHold), .chanClear(chanClear),
    .twoByteMode(twoByteMode)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic expHost(input logic [5:0] c);
    return c[0] && ch4HostData;
  endfunction
  function automatic logic expPirq(input logic [5:0] c);
    return (c[1] && ch1ParData) || (c[2] && ch4ParData);
  endfunction
  function automatic logic expNmi(input logic [5:0] c);
    return c[3] && ch3ParData;
  endfunction

  task automatic checkIrqs(input logic [5:0] c);
    chk("R8 hostIrq", {7'd0, hostIrq}, {7'd0, expHost(c)});
    chk("R9 parIrq", {7'd0, parIrq}, {7'd0, expPirq(c)});
    chk("R10 parNmi", {7'd0, parNmi}, {7'd0, expNmi(c)});
  endtask

  // Write at a falling edge, check strobes/readback one edge later, then
  // interrupts and hold two edges later.
  task automatic ctrlWrite(input logic [7:0] d);
    logic expClr, expRst;
    expClr = d[7] && d[6];
    expRst = !d[7] && d[5] && model[5];
    hostWr = 1'b1; hostAddr = '0; hostWrData = d;
    @(negedge clk);
    hostWr = 1'b0;
    model = d[7] ? (model | d[5:0]) : (model & ~d[5:0]);
    chk(d[7] ? "R2 readback" : "R3 readback", hostRdData, {ch1HostFlags, model});
    chk("R5 chanClear", {7'd0, chanClear}, {7'd0, expClr});
    chk("R6 parResetPulse", {7'd0, parResetPulse}, {7'd0, expRst});
    @(negedge clk);
    chk("R5 strobe one cycle", {7'd0, chanClear}, 8'd0);
    chk("R6 pulse one cycle", {7'd0, parResetPulse}, 8'd0);
    chk("R7 parHold", {7'd0, parHold}, {7'd0, model[5]});
    chk("R12 twoByteMode", {7'd0, twoByteMode}, {7'd0, model[4]});
    checkIrqs(model);
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    chk("R1 outputs", {2'b0, hostIrq, parIrq, parNmi, parResetPulse, parHold, chanClear}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 readback", hostRdData, 8'h00);
    chk("R1 outputs", {1'b0, twoByteMode, hostIrq, parIrq, parNmi, parResetPulse, parHold, chanClear}, 8'd0);

    // R4 flags and offset
    ch1HostFlags = 2'b10; #1;
    chk("R4 status flags", hostRdData, 8'h80);
    hostAddr = 3'd3; #1;
    chk("R4 other offset", hostRdData, 8'h00);
    hostAddr = '0; ch1HostFlags = 2'b01; #1;
    chk("R4 status flags", hostRdData, 8'h40);

    // R6: clear of bit5 while already 0 gives no pulse; then set/clear gives pulse
    ctrlWrite(8'h20);
    ctrlWrite(8'hA0);
    ctrlWrite(8'h20);
    // R5 repeated clear strobes, control unchanged
    ctrlWrite(8'hC0);
    ctrlWrite(8'hC0);
    // R3 keeps unselected bits
    ctrlWrite(8'hBF);
    ctrlWrite(8'h0A);
    // R12: two-byte mode has no effect on irqs
    ch3ParData = 1'b1; ch1ParData = 1'b1; ch4ParData = 1'b1; ch4HostData = 1'b1;
    ctrlWrite(8'h3F);
    ctrlWrite(8'h90);
    @(negedge clk);
    checkIrqs(model);

    // R11 latency: enable host irq, toggle flag, check before and after edge
    ch4HostData = 1'b0; ch1ParData = 1'b0; ch3ParData = 1'b0; ch4ParData = 1'b0;
    ctrlWrite(8'h8F);
    ch4HostData = 1'b1; ch3ParData = 1'b1;
    #2;
    chk("R11 hostIrq before edge", {7'd0, hostIrq}, 8'd0);
    chk("R11 parNmi before edge", {7'd0, parNmi}, 8'd0);
    @(negedge clk);
    chk("R11 hostIrq after edge", {7'd0, hostIrq}, 8'd1);
    chk("R11 parNmi after edge", {7'd0, parNmi}, 8'd1);
    // R11: control change takes two edges
    hostWr = 1'b1; hostWrData = 8'h01;
    @(negedge clk);
    hostWr = 1'b0; model[0] = 1'b0;
    chk("R11 hostIrq one edge after write", {7'd0, hostIrq}, 8'd1);
    @(negedge clk);
    chk("R11 hostIrq two edges after write", {7'd0, hostIrq}, 8'd0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] d;
      ch1HostFlags = 2'($urandom);
      ch4HostData  = 1'($urandom);
      ch1ParData   = 1'($urandom);
      ch3ParData   = 1'($urandom);
      ch4ParData   = 1'($urandom);
      d = 8'($urandom);
      if ($urandom_range(3) == 0) begin
        hostAddr = 3'($urandom_range(7, 1));
        hostWr = 1'b1; hostWrData = d;
        @(negedge clk);
        hostWr = 1'b0;
        chk("R4 non-zero offset read", hostRdData, 8'h00);
        hostAddr = '0; #1;
        chk("R4 write elsewhere ignored", hostRdData, {ch1HostFlags, model});
        @(negedge clk);
        checkIrqs(model);
      end else begin
        ctrlWrite(d);
      end
    end

    // R1 reset mid-run clears control
    ctrlWrite(8'hBF);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1; model = '0;
    @(negedge clk);
    chk("R1 reset clears control", {2'b0, hostRdData[5:0]}, 8'd0);
    chk("R1 hold after reset", {7'd0, parHold}, 8'd0);

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule